// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

This block joins a 16-bit CPU address/data port (X) to two interleaved memory banks, an even bank (Y) and an odd bank (Z). Each direction toward each bank has its own holding stage, so there are four stages: two write stages (X toward Y, X toward Z) and two read stages (Y toward X, Z toward X). Each stage has its own capture enable. While the enable is high, the stage passes its input straight through. Once the enable drops, the stage keeps the value it took at the last clock edge where the enable was high.

Four controls set how data moves. A bank select picks which memory bank is paired with X. A direction input picks write (X is the source) or read (X is driven). Two active-low byte-lane enables gate the upper and lower bytes. Every port is modelled as an input bus, an output bus and a two-bit per-byte output-enable vector (bit 1 is the upper byte, bit 0 the lower byte).

The bank select does not gate the capture enables. A controller can therefore present one bank's held data on X while the other bank captures its next word, which gives two-way interleaved reads. A write stage keeps its data after the CPU releases its bus, so it acts as a one-entry write buffer toward its bank.

Top module: `bus_exchanger`

## Requirements
- R1: While `cap_wr_y` is high, `y_out` equals `x_in` in the same cycle. While `cap_wr_z` is high, `z_out` equals `x_in` in the same cycle.
- R2: After a write stage's enable goes low, its output keeps the `x_in` value from the last rising clock edge at which the enable was high. Later changes of `x_in` do not affect it.
- R3: A read stage (`cap_rd_y` for `y_in`, `cap_rd_z` for `z_in`) is transparent while its enable is high. While the enable is low, it holds the value from the last rising edge at which the enable was high.
- R4: `x_out` shows the Y read stage when `bank_even` is 1 and the Z read stage when `bank_even` is 0.
- R5: `x_oe[1]` is 1 exactly when `to_mem` is 0 and `up_n` is 0. `x_oe[0]` is 1 exactly when `to_mem` is 0 and `lo_n` is 0.
- R6: `y_oe[i]` is 1 exactly when `to_mem` is 1, `bank_even` is 1 and the lane's active-low enable is 0. `z_oe[i]` is 1 exactly when `to_mem` is 1, `bank_even` is 0 and that lane's enable is 0. Lane 1 uses `up_n` and lane 0 uses `lo_n`.
- R7: When `up_n` and `lo_n` are both 1, all six output-enable bits are 0, whatever `bank_even` and `to_mem` are.
- R8: At any time at most one of the groups `x_oe`, `y_oe` and `z_oe` has a bit set.
- R9: `bank_even` does not gate any capture enable. A read stage captures while the other bank's stage is shown on `x_out`.
- R10: After reset, all four stages hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the held values |
| bank_even | input | 1 | 1 pairs X with Y, 0 pairs X with Z |
| to_mem | input | 1 | 1 means write (X is the source), 0 means read (X is driven) |
| up_n | input | 1 | Active-low enable for bits 15:8 |
| lo_n | input | 1 | Active-low enable for bits 7:0 |
| cap_wr_y | input | 1 | Capture enable of the X-to-Y write stage |
| cap_wr_z | input | 1 | Capture enable of the X-to-Z write stage |
| cap_rd_y | input | 1 | Capture enable of the Y-to-X read stage |
| cap_rd_z | input | 1 | Capture enable of the Z-to-X read stage |
| x_in | input | 16 | Data arriving at the CPU port |
| y_in | input | 16 | Data arriving at the even bank port |
| z_in | input | 16 | Data arriving at the odd bank port |
| x_out | output | 16 | Data driven onto the CPU port |
| x_oe | output | 2 | Per-byte drive enables of the CPU port |
| y_out | output | 16 | Data driven onto the even bank port |
| y_oe | output | 2 | Per-byte drive enables of the even bank port |
| z_out | output | 16 | Data driven onto the odd bank port |
| z_oe | output | 2 | Per-byte drive enables of the odd bank port |

## Verification
The bench sweeps all sixteen combinations of bank select, direction and the two byte enables. This shows whether each enable group decodes its lanes independently, whether the all-disabled case overrides the other controls, and whether two groups are ever enabled at once.

Each stage is driven with one value while its enable is high and a different value after the enable drops. This tells transparent pass-through apart from holding the captured word.

Last, an interleaved read flips the bank select every cycle while the opposite bank captures. It shows that X presents the bank words in order and that capture does not depend on the bank select.

// File: rtl/exch_pkg.sv
package exch_pkg;

    typedef struct packed {
        logic bank_even;
        logic to_mem;
        logic up_n;
        logic lo_n;
    } exch_ctrl_t;

    typedef struct packed {
        logic [1:0] x;
        logic [1:0] y;
        logic [1:0] z;
    } exch_oe_t;

endpackage

// File: rtl/exch_stage.sv
module exch_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [DATA_W-1:0] held;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.held = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Transparent while open, held value once closed.
    assign dout = cap ? din : st_q.held;
endmodule

// File: rtl/exch_oe_decode.sv
module exch_oe_decode
    import exch_pkg::*;
(
    input  exch_ctrl_t ctrl,
    output exch_oe_t   oe
);
    logic [1:0] lane_on;

    always_comb begin
        lane_on = {~ctrl.up_n, ~ctrl.lo_n};
        oe.x    = lane_on & {2{~ctrl.to_mem}};
        oe.y    = lane_on & {2{ctrl.to_mem & ctrl.bank_even}};
        oe.z    = lane_on & {2{ctrl.to_mem & ~ctrl.bank_even}};
    end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
    import exch_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_even,
    input  logic              to_mem,
    input  logic              up_n,
    input  logic              lo_n,
    input  logic              cap_wr_y,
    input  logic              cap_wr_z,
    input  logic              cap_rd_y,
    input  logic              cap_rd_z,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] y_in,
    input  logic [DATA_W-1:0] z_in,
    output logic [DATA_W-1:0] x_out,
    output logic [1:0]        x_oe,
    output logic [DATA_W-1:0] y_out,
    output logic [1:0]        y_oe,
    output logic [DATA_W-1:0] z_out,
    output logic [1:0]        z_oe
);
    localparam int NSTAGE = 4;
    localparam int SRC_XY = 0;
    localparam int SRC_XZ = 1;
    localparam int SRC_YX = 2;
    localparam int SRC_ZX = 3;

    logic [NSTAGE-1:0]             cap_vec;
    logic [NSTAGE-1:0][DATA_W-1:0] din_vec;
    logic [NSTAGE-1:0][DATA_W-1:0] dout_vec;
    exch_ctrl_t                    ctrl;
    exch_oe_t                      oe;

    assign cap_vec[SRC_XY] = cap_wr_y;
    assign cap_vec[SRC_XZ] = cap_wr_z;
    assign cap_vec[SRC_YX] = cap_rd_y;
    assign cap_vec[SRC_ZX] = cap_rd_z;
    assign din_vec[SRC_XY] = x_in;
    assign din_vec[SRC_XZ] = x_in;
    assign din_vec[SRC_YX] = y_in;
    assign din_vec[SRC_ZX] = z_in;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        exch_stage #(.DATA_W(DATA_W)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .cap  (cap_vec[g]),
            .din  (din_vec[g]),
            .dout (dout_vec[g])
        );
    end

    assign ctrl = '{bank_even: bank_even, to_mem: to_mem, up_n: up_n, lo_n: lo_n};

    exch_oe_decode u_dec (
        .ctrl(ctrl),
        .oe  (oe)
    );

    assign y_out = dout_vec[SRC_XY];
    assign z_out = dout_vec[SRC_XZ];
    assign x_out = bank_even ? dout_vec[SRC_YX] : dout_vec[SRC_ZX];
    assign x_oe  = oe.x;
    assign y_oe  = oe.y;
    assign z_oe  = oe.z;
endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_even,
    input logic              to_mem,
    input logic              up_n,
    input logic              lo_n,
    input logic              cap_wr_y,
    input logic              cap_wr_z,
    input logic              cap_rd_y,
    input logic              cap_rd_z,
    input logic [DATA_W-1:0] x_in,
    input logic [DATA_W-1:0] y_in,
    input logic [DATA_W-1:0] z_in,
    input logic [DATA_W-1:0] x_out,
    input logic [1:0]        x_oe,
    input logic [DATA_W-1:0] y_out,
    input logic [1:0]        y_oe,
    input logic [DATA_W-1:0] z_out,
    input logic [1:0]        z_oe
);
    AST_WR_Y_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr_y |-> (y_out == x_in)); // R1

    AST_WR_Y_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_wr_y && $past(!cap_wr_y)) |-> $stable(y_out)); // R2

    AST_WR_Z_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_wr_z && $past(!cap_wr_z)) |-> $stable(z_out)); // R2

    AST_RD_Y_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_even && $past(bank_even) && !cap_rd_y && $past(!cap_rd_y)) |-> $stable(x_out)); // R3

    AST_RD_Z_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_even && cap_rd_z) |-> (x_out == z_in)); // R9

    AST_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && lo_n) |-> ({x_oe, y_oe, z_oe} == 6'b0)); // R7

    AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|x_oe, |y_oe, |z_oe})); // R8

    AST_X_QUIET_WR: assert property (@(posedge clk) disable iff (!rst_n)
        to_mem |-> (x_oe == 2'b00)); // R5
endmodule

bind bus_exchanger bus_exchanger_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bus_exchanger_test.sv
module bus_exchanger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_even = 1'b1, to_mem = 1'b0, up_n = 1'b1, lo_n = 1'b1;
    logic        cap_wr_y = 1'b0, cap_wr_z = 1'b0, cap_rd_y = 1'b0, cap_rd_z = 1'b0;
    logic [15:0] x_in = '0, y_in = '0, z_in = '0;
    logic [15:0] x_out, y_out, z_out;
    logic [1:0]  x_oe, y_oe, z_oe;
    int          checks = 0;
    int          failures = 0;

    always #10 clk = ~clk;

    bus_exchanger uut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] yv, zv, prev;
        repeat (3) step();
        rst_n = 1'b1;
        #5;
        // R10 reset state
        chk("R10 x_out", x_out, 16'h0);
        chk("R10 y_out", y_out, 16'h0);
        chk("R10 z_out", z_out, 16'h0);

        // Sweep all controls: R5 R6 R7 R8
        for (int c = 0; c < 16; c++) begin
            logic [1:0] ln, ex, ey, ez;
            step();
            bank_even = c[3]; to_mem = c[2]; up_n = c[1]; lo_n = c[0];
            #5;
            ln = {~up_n, ~lo_n};
            ex = to_mem ? 2'b00 : ln;
            ey = (to_mem && bank_even) ? ln : 2'b00;
            ez = (to_mem && !bank_even) ? ln : 2'b00;
            chk("R5 x_oe", {14'b0, x_oe}, {14'b0, ex});
            chk("R6 y_oe", {14'b0, y_oe}, {14'b0, ey});
            chk("R6 z_oe", {14'b0, z_oe}, {14'b0, ez});
            if (up_n && lo_n)
                chk("R7 all oe", {10'b0, x_oe, y_oe, z_oe}, 16'h0);
            chk("R8 groups", 16'(((|x_oe) ? 1 : 0) + ((|y_oe) ? 1 : 0) + ((|z_oe) ? 1 : 0) > 1), 16'h0);
        end

        // Write stage Y: R1 then R2
        step(); up_n = 1'b0; lo_n = 1'b0; to_mem = 1'b1; bank_even = 1'b1;
        cap_wr_y = 1'b1; x_in = 16'hA5C3; #5;
        chk("R1 y pass", y_out, 16'hA5C3);
        chk("R2 z untouched", z_out, 16'h0);
        step(); cap_wr_y = 1'b0; x_in = 16'h1111; #5;
        chk("R2 y hold", y_out, 16'hA5C3);
        step(); x_in = 16'h2222; #5;
        chk("R2 y buffer", y_out, 16'hA5C3);
        // Write stage Z
        step(); bank_even = 1'b0; cap_wr_z = 1'b1; x_in = 16'h3C5A; #5;
        chk("R1 z pass", z_out, 16'h3C5A);
        chk("R2 y still", y_out, 16'hA5C3);
        step(); cap_wr_z = 1'b0; x_in = 16'hFFFF; #5;
        chk("R2 z hold", z_out, 16'h3C5A);

        // Read stage Y: R3, R4
        step(); to_mem = 1'b0; bank_even = 1'b1; cap_rd_y = 1'b1; y_in = 16'h7E81; #5;
        chk("R3 y pass", x_out, 16'h7E81);
        step(); cap_rd_y = 1'b0; y_in = 16'h0F0F; #5;
        chk("R3 y hold", x_out, 16'h7E81);
        // R9: capture Z while Y shown on X
        step(); cap_rd_z = 1'b1; z_in = 16'h4D2B; #5;
        chk("R9 x shows y", x_out, 16'h7E81);
        step(); cap_rd_z = 1'b0; z_in = 16'h9999; bank_even = 1'b0; #5;
        chk("R4 x shows z", x_out, 16'h4D2B);
        step(); bank_even = 1'b1; #5;
        chk("R4 x back to y", x_out, 16'h7E81);

        // Interleaved read: R9 R4
        step(); cap_rd_y = 1'b1; y_in = 16'h1000; bank_even = 1'b0; #5;
        prev = 16'h1000;
        for (int k = 0; k < 8; k++) begin
            yv = 16'h1000 + 16'(k + 1) * 16'd3;
            zv = 16'h2000 + 16'(k) * 16'd5;
            step();
            if (k[0] == 1'b0) begin
                bank_even = 1'b1; cap_rd_y = 1'b0; cap_rd_z = 1'b1; z_in = zv; y_in = 16'hDEAD;
            end else begin
                bank_even = 1'b0; cap_rd_z = 1'b0; cap_rd_y = 1'b1; y_in = yv; z_in = 16'hBEEF;
            end
            #5;
            chk("R9 interleave", x_out, prev);
            prev = (k[0] == 1'b0) ? zv : yv;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule